// File: doc/BRIEF.md
# Enable Pin Sleep and Fault-Reset Sequencer

This block turns one asynchronous enable pin and a synchronous supply-undervoltage flag into the power-state sequence of a gate-driver die. It produces enables for the charge pump, the internal regulator, the serial bus and the gate drivers. It also drives a ready flag for the input logic and a one-cycle fault-clear strobe for the fault manager.

The enable pin does two jobs, and the length of its low time tells them apart. A short high-low-high dip is a fault reset: the strobe fires and nothing else changes. A dip longer than the reset window but within the sleep delay is forgiven, and the block stays operating with no strobe. Only a low time that outlasts the sleep delay powers the die down. Leaving sleep needs the enable high and the supply good. Ready and the gate drivers then follow after a wake delay. Undervoltage forces the gate drivers off at any time.

Top module: `pwr_seq_ctrl`

## Requirements
- R1: During and straight after reset, every enable output, `ready` and `flt_clr` are low, and the block is asleep.
- R2: While asleep, `pump_en`, `ldo_en`, `bus_en`, `gate_en` and `ready` are all low.
- R3: In the cycle after `uv_flag` is sampled high, `gate_en` is low, whatever the enable level. Undervoltage sampled while operating with the enable high drops `ready` and restarts the wake delay.
- R4: From sleep, when the synchronized enable is high and `uv_flag` is low, `pump_en`, `ldo_en` and `bus_en` rise. `ready` and `gate_en` rise `WAKE_DLY` cycles later, counting only cycles with `uv_flag` low; a low enable during wake-up returns to sleep.
- R5: While operating, a low time of L synchronized cycles with 1 <= L <= `RST_WIN` gives exactly one `flt_clr` cycle, one cycle after the synchronized rising edge. `ready`, `ldo_en`, `pump_en` and `bus_en` stay high throughout.
- R6: A low time with `RST_WIN` < L <= `SLEEP_DLY` gives no strobe. The block returns to operating with `ready` held high throughout.
- R7: A low time L > `SLEEP_DLY` puts the block to sleep, and every enable output is low from then on.
- R8: `en_pin` passes through `SYNC_STAGES` flip-flops (default 2) before the sequencer acts on it. A change on the pin first shows at the outputs `SYNC_STAGES` + 1 cycles after the edge that samples it. `RST_WIN` must be smaller than `SLEEP_DLY`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_pin | input | 1 | Asynchronous enable pin |
| uv_flag | input | 1 | Supply below undervoltage limit, synchronous |
| pump_en | output | 1 | Charge pump enable |
| ldo_en | output | 1 | Internal regulator enable |
| bus_en | output | 1 | Serial bus enable |
| gate_en | output | 1 | Gate driver enable; low commands every external switch off |
| ready | output | 1 | Block accepts control inputs |
| flt_clr | output | 1 | One-cycle fault-reset strobe to the fault manager |

## Verification
A corrupted low-time counter shows at the ports as a strobe where none belongs, a missing strobe, or a sleep entry that comes early or late. The reference model catches each of these in the first cycle the pulse classification or the sleep edge diverges. A wrong wake counter moves the rise of `ready` and `gate_en` and is seen in that cycle. A stuck state register shows at once as regulator enables that disagree with the pin and supply history.

// File: rtl/pmc_pkg.sv
package pmc_pkg;

    typedef enum logic [1:0] {
        PS_SLEEP  = 2'd0,
        PS_WAKE   = 2'd1,
        PS_RUN    = 2'd2,
        PS_LOWCHK = 2'd3
    } pmc_state_e;

    typedef struct packed {
        logic pump;
        logic ldo;
        logic bus;
        logic gate;
        logic ready;
        logic clr;
    } pmc_out_t;

endpackage

// File: rtl/pmc_sync.sv
module pmc_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic q_sync
);
    logic [STAGES-1:0] chain_q;

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[0] <= 1'b0;
                    else        chain_q[0] <= d_async;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[g] <= 1'b0;
                    else        chain_q[g] <= chain_q[g-1];
                end
            end
        end
    endgenerate

    assign q_sync = chain_q[STAGES-1];
endmodule

// File: rtl/pmc_fsm.sv
module pmc_fsm
    import pmc_pkg::*;
#(
    parameter int RST_WIN   = 8,
    parameter int SLEEP_DLY = 40,
    parameter int WAKE_DLY  = 20
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en_s,
    input  logic       uv,
    output pmc_out_t   outs,
    output pmc_state_e state
);
    localparam int MAXC = (SLEEP_DLY > WAKE_DLY) ? SLEEP_DLY : WAKE_DLY;
    localparam int CW   = $clog2(MAXC + 1);
    localparam logic [CW-1:0] SLP_LAST  = CW'(SLEEP_DLY - 1);
    localparam logic [CW-1:0] WAKE_LAST = CW'(WAKE_DLY - 1);
    localparam logic [CW-1:0] WIN_LIM   = CW'(RST_WIN);

    typedef struct packed {
        pmc_state_e st;
        logic [CW-1:0] cnt;
        pmc_out_t   o;
    } fsm_reg_t;

    fsm_reg_t r_q, r_d;

    always_comb begin
        r_d       = r_q;
        r_d.o.clr = 1'b0;
        unique case (r_q.st)
            PS_SLEEP: begin
                if (en_s && !uv) begin
                    r_d.st  = PS_WAKE;
                    r_d.cnt = '0;
                end
            end
            PS_WAKE: begin
                if (!en_s) begin
                    r_d.st = PS_SLEEP;
                end else if (uv) begin
                    r_d.cnt = '0;
                end else if (r_q.cnt == WAKE_LAST) begin
                    r_d.st = PS_RUN;
                end else begin
                    r_d.cnt = r_q.cnt + 1'b1;
                end
            end
            PS_RUN: begin
                if (!en_s) begin
                    r_d.st  = PS_LOWCHK;
                    r_d.cnt = '0;
                end else if (uv) begin
                    r_d.st  = PS_WAKE;
                    r_d.cnt = '0;
                end
            end
            PS_LOWCHK: begin
                if (en_s) begin
                    r_d.st    = PS_RUN;
                    r_d.o.clr = (r_q.cnt < WIN_LIM);
                end else if (r_q.cnt == SLP_LAST) begin
                    r_d.st = PS_SLEEP;
                end else begin
                    r_d.cnt = r_q.cnt + 1'b1;
                end
            end
            default: r_d.st = PS_SLEEP;
        endcase

        r_d.o.pump  = (r_d.st != PS_SLEEP);
        r_d.o.ldo   = (r_d.st != PS_SLEEP);
        r_d.o.bus   = (r_d.st != PS_SLEEP);
        r_d.o.ready = (r_d.st == PS_RUN) || (r_d.st == PS_LOWCHK);
        r_d.o.gate  = r_d.o.ready && !uv;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: PS_SLEEP, cnt: '0, o: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign outs  = r_q.o;
    assign state = r_q.st;
endmodule

// File: rtl/pwr_seq_ctrl.sv
module pwr_seq_ctrl
    import pmc_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int RST_WIN     = 8,
    parameter int SLEEP_DLY   = 40,
    parameter int WAKE_DLY    = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_pin,
    input  logic uv_flag,
    output logic pump_en,
    output logic ldo_en,
    output logic bus_en,
    output logic gate_en,
    output logic ready,
    output logic flt_clr
);
    logic       en_sync;
    pmc_out_t   seq_out;
    pmc_state_e seq_state;

    pmc_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .d_async(en_pin),
        .q_sync (en_sync)
    );

    pmc_fsm #(
        .RST_WIN  (RST_WIN),
        .SLEEP_DLY(SLEEP_DLY),
        .WAKE_DLY (WAKE_DLY)
    ) u_fsm (
        .clk  (clk),
        .rst_n(rst_n),
        .en_s (en_sync),
        .uv   (uv_flag),
        .outs (seq_out),
        .state(seq_state)
    );

    assign pump_en = seq_out.pump;
    assign ldo_en  = seq_out.ldo;
    assign bus_en  = seq_out.bus;
    assign gate_en = seq_out.gate;
    assign ready   = seq_out.ready;
    assign flt_clr = seq_out.clr;
endmodule

// File: rtl/pwr_seq_ctrl_chk.sv
module pwr_seq_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic en_sync,
    input logic uv_flag,
    input logic pump_en,
    input logic ldo_en,
    input logic bus_en,
    input logic gate_en,
    input logic ready,
    input logic flt_clr
);
    p_sleep_all_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !ldo_en |-> (!pump_en && !bus_en && !gate_en && !ready));

    p_uv_gate_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
        uv_flag |=> !gate_en);

    p_ready_needs_power_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> (ldo_en && pump_en && bus_en));

    p_ready_after_wake_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready) |-> $past(ldo_en));

    p_strobe_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        flt_clr |=> !flt_clr);

    p_strobe_keeps_power_r5: assert property (@(posedge clk) disable iff (!rst_n)
        flt_clr |-> (ready && ldo_en && $past(ready)));

    p_strobe_after_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
        flt_clr |-> $past(en_sync));

    p_sleep_needs_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ready) && !uv_flag && !$past(uv_flag) |-> !$past(en_sync));
endmodule

bind pwr_seq_ctrl pwr_seq_ctrl_chk u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .en_sync(en_sync),
    .uv_flag(uv_flag),
    .pump_en(pump_en),
    .ldo_en (ldo_en),
    .bus_en (bus_en),
    .gate_en(gate_en),
    .ready  (ready),
    .flt_clr(flt_clr)
);

// File: tb/test_pwr_seq_ctrl.sv
module test_pwr_seq_ctrl;
    localparam int RW = 8;
    localparam int SD = 40;
    localparam int WD = 20;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en_pin = 1'b0;
    logic uv_flag = 1'b0;
    logic pump_en, ldo_en, bus_en, gate_en, ready, flt_clr;

    int vectors = 0;
    int errors = 0;
    int cycles = 0;
    int strobes = 0;
    string tag = "R1";

    // reference model state
    bit p1 = 0, p2 = 0;
    int mode = 0;          // 0 asleep, 1 waking, 2 on, 3 enable low while on
    int good_cycles = 0;   // uv-free cycles counted during wake
    int low_len = 0;       // synchronized low cycles seen while on
    bit e_pwr = 0, e_rdy = 0, e_gate = 0, e_clr = 0;

    always #2 clk = ~clk;

    pwr_seq_ctrl #(.SYNC_STAGES(2), .RST_WIN(RW), .SLEEP_DLY(SD), .WAKE_DLY(WD)) i_pwr_seq_ctrl (
        .clk(clk), .rst_n(rst_n), .en_pin(en_pin), .uv_flag(uv_flag),
        .pump_en(pump_en), .ldo_en(ldo_en), .bus_en(bus_en),
        .gate_en(gate_en), .ready(ready), .flt_clr(flt_clr)
    );

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            p1 = 0; p2 = 0; mode = 0; good_cycles = 0; low_len = 0;
            e_pwr = 0; e_rdy = 0; e_gate = 0; e_clr = 0;
        end else begin
            e_clr = 0;
            if (mode == 0) begin
                if (p2 && !uv_flag) begin mode = 1; good_cycles = 0; end
            end else if (mode == 1) begin
                if (!p2) mode = 0;
                else if (uv_flag) good_cycles = 0;
                else begin
                    good_cycles++;
                    if (good_cycles >= WD) mode = 2;
                end
            end else if (mode == 2) begin
                if (!p2) begin mode = 3; low_len = 1; end
                else if (uv_flag) begin mode = 1; good_cycles = 0; end
            end else begin
                if (p2) begin
                    e_clr = (low_len <= RW);
                    mode = 2;
                end else begin
                    low_len++;
                    if (low_len > SD) mode = 0;
                end
            end
            e_pwr  = (mode != 0);
            e_rdy  = (mode >= 2);
            e_gate = e_rdy && !uv_flag;
            p2 = p1;
            p1 = en_pin;
        end
    end

    task automatic cmp(input string what, input bit act, input bit exp);
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0b expected %0b at cycle %0d", tag, what, act, exp, cycles);
        end
    endtask

    always @(negedge clk) begin
        cycles++;
        vectors++;
        cmp("pump_en", pump_en, e_pwr);
        cmp("ldo_en", ldo_en, e_pwr);
        cmp("bus_en", bus_en, e_pwr);
        cmp("ready", ready, e_rdy);
        cmp("gate_en", gate_en, e_gate);
        cmp("flt_clr", flt_clr, e_clr);
        if (flt_clr === 1'b1) strobes++;
        if (cycles > 100000) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    task automatic wait_cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic directed(input string what, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic low_pulse(input int len);
        en_pin = 1'b0;
        wait_cyc(len);
        en_pin = 1'b1;
    endtask

    initial begin
        tag = "R1";
        wait_cyc(4);
        directed("ldo in reset", ldo_en, 0);
        rst_n = 1'b1;
        wait_cyc(1);
        directed("ready after reset", ready, 0);
        directed("strobe after reset", flt_clr, 0);

        tag = "R2";
        wait_cyc(10);
        directed("asleep pump", pump_en, 0);

        tag = "R8";
        en_pin = 1'b1;
        wait_cyc(2);
        directed("no power before sync", ldo_en, 0);
        wait_cyc(1);
        directed("power after sync", ldo_en, 1);

        tag = "R4";
        wait_cyc(WD - 2);
        directed("ready not yet", ready, 0);
        wait_cyc(3);
        directed("ready after wake", ready, 1);
        directed("gate after wake", gate_en, 1);

        tag = "R5";
        strobes = 0;
        low_pulse(1); wait_cyc(6);
        low_pulse(5); wait_cyc(6);
        low_pulse(RW); wait_cyc(6);
        directed("strobe count", strobes, 3);
        directed("ready kept", ready, 1);

        tag = "R6";
        strobes = 0;
        low_pulse(RW + 1); wait_cyc(6);
        low_pulse(SD); wait_cyc(6);
        directed("no strobe", strobes, 0);
        directed("still ready", ready, 1);

        tag = "R3";
        uv_flag = 1'b1;
        wait_cyc(2);
        directed("gate off on uv", gate_en, 0);
        directed("ready drops on uv", ready, 0);
        wait_cyc(5);
        uv_flag = 1'b0;
        wait_cyc(WD / 2);
        uv_flag = 1'b1;
        wait_cyc(3);
        uv_flag = 1'b0;
        wait_cyc(WD + 3);
        directed("ready after uv", ready, 1);
        en_pin = 1'b0;
        wait_cyc(4);
        uv_flag = 1'b1;
        wait_cyc(2);
        directed("gate off uv while low", gate_en, 0);
        uv_flag = 1'b0;
        en_pin = 1'b1;
        wait_cyc(8);

        tag = "R7";
        low_pulse(SD + 1);
        wait_cyc(2);
        directed("asleep after long low", ldo_en, 0);
        wait_cyc(WD + 4);
        en_pin = 1'b0;
        wait_cyc(SD + 8);
        directed("asleep after hold low", pump_en, 0);

        tag = "R4";
        uv_flag = 1'b1;
        en_pin = 1'b1;
        wait_cyc(8);
        directed("no wake under uv", ldo_en, 0);
        uv_flag = 1'b0;
        wait_cyc(6);
        en_pin = 1'b0;
        wait_cyc(6);
        directed("wake aborted", ldo_en, 0);

        tag = "R5";
        en_pin = 1'b1;
        wait_cyc(WD + 6);
        strobes = 0;
        low_pulse(2); wait_cyc(5);
        directed("strobe after rewake", strobes, 1);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule